// File: doc/BRIEF.md
# Channel Loop Interrupt Controller

This block collects interrupt events for an audio engine with 64 voice channels and drives one level interrupt line to the host. General event sources set bits in a 32-bit pending register. An enable register of the same width gates them onto the line. The host clears pending bits by writing ones to them.

The voice engine also reports, per channel, a "loop reached" event and a "half loop reached" event. The block keeps one loop flag and one half-loop flag per channel. A single summary bit in the pending word reads as one while any of these flags is set. While it is set, the six lowest bits of the pending word give the highest channel that has a flag set. The host clears one channel at a time by writing the pending register with the summary bit set and the channel number in the low bits. A force bit in the enable register holds the interrupt line high whatever the pending state.

Register access uses a plain synchronous bus. A write takes effect on the clock edge that samples it. Read data is combinational from the stored state. There is no data stream, so no valid/ready handshake and no back-pressure apply. Every pin is plain control or status.

Top module: `irq_loop_ctrl`

## Requirements
- R1: After reset, the pending word and the enable word both read as zero, and `irq_o` is low.
- R2: A write to the pending register (`reg_sel_i`=0) clears every bit in 31:7 that is written as 1. Bits in 31:7 written as 0 keep their value. Source pulse `src_set_i[k]` sets pending bit k+7.
- R3: If a source pulse and a host clear hit the same pending bit in one cycle, the bit ends up set.
- R4: Pending bit 6 reads as 1 exactly when at least one channel has its loop flag or its half-loop flag set. A pulse on `loop_set_i[c]` sets the loop flag of channel c, and a pulse on `half_set_i[c]` sets its half-loop flag.
- R5: While bit 6 is set, pending bits 5:0 give the highest channel number that has a loop or half-loop flag set. While bit 6 is clear, bits 5:0 read as zero.
- R6: A pending write with bit 6 set clears both flags of the channel named in bits 5:0 and leaves all other channels alone. A pending write with bit 6 clear changes no channel flag.
- R7: If a channel receives a loop or half-loop pulse in the same cycle that a write clears that channel, the flag ends up set.
- R8: A write with `reg_sel_i`=1 loads all 32 bits of the enable word, and the value reads back unchanged.
- R9: Pending bit i interrupts only when enable bit i is set, for i from 6 to 31. `irq_o` is high one cycle after the AND of those bits becomes non-zero, and low one cycle after it becomes zero.
- R10: While enable bit 20 is set, `irq_o` is high one cycle later, whatever the pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 1 | Register select: 0 = pending word, 1 = enable word |
| reg_wr_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| src_set_i | input | 25 | Event pulses for pending bits 31:7 |
| loop_set_i | input | 64 | Per-channel loop event pulses |
| half_set_i | input | 64 | Per-channel half-loop event pulses |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
A write or a source pulse applied before clock edge N is visible in `reg_rdata_o` right after edge N, because read data is combinational from the registers. `irq_o` is registered one stage later and follows at edge N+1. Each check therefore drives its inputs on a falling edge, lets two rising edges pass, and samples both the read data and the line on the next falling edge. Both results are settled by then. The checks for same-cycle collisions present the pulse and the conflicting write in the same driven cycle, so that one edge resolves both.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    SEL_PEND = 1'b0,
    SEL_EN   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_gen_pending.sv
module irq_gen_pending #(
  parameter int SRC_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] set_i,
  input  logic [SRC_W-1:0] clr_i,
  output logic [SRC_W-1:0] pend_o
);
  logic [SRC_W-1:0] pend_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_loop_bank.sv
module irq_loop_bank #(
  parameter int NUM_CH = 64,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] loop_set_i,
  input  logic [NUM_CH-1:0] half_set_i,
  input  logic              clr_en_i,
  input  logic [CH_W-1:0]   clr_ch_i,
  output logic              any_o,
  output logic [CH_W-1:0]   top_ch_o
);
  logic [NUM_CH-1:0] loop_q, half_q, clr_mask, active;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_dec
      assign clr_mask[g] = clr_en_i && (clr_ch_i == CH_W'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q <= '0;
      half_q <= '0;
    end else begin
      loop_q <= (loop_q & ~clr_mask) | loop_set_i;
      half_q <= (half_q & ~clr_mask) | half_set_i;
    end
  end

  assign active = loop_q | half_q;
  assign any_o  = |active;

  // highest active channel wins; zero when nothing active
  always_comb begin
    top_ch_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (active[i]) top_ch_o = CH_W'(i);
    end
  end
endmodule

// File: rtl/irq_line.sv
module irq_line #(
  parameter int DATA_W    = 32,
  parameter int LOW_W     = 6,
  parameter int FORCE_BIT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pend_i,
  input  logic [DATA_W-1:0] en_i,
  output logic              irq_o
);
  logic irq_q, irq_d;

  assign irq_d = (|(pend_i[DATA_W-1:LOW_W] & en_i[DATA_W-1:LOW_W])) | en_i[FORCE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_loop_ctrl.sv
module irq_loop_ctrl #(
  parameter int DATA_W    = 32,
  parameter int NUM_CH    = 64,
  parameter int FORCE_BIT = 20,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int SUM_BIT  = CH_W,
  localparam int SRC_LO   = CH_W + 1,
  localparam int SRC_W    = DATA_W - SRC_LO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [SRC_W-1:0]  src_set_i,
  input  logic [NUM_CH-1:0] loop_set_i,
  input  logic [NUM_CH-1:0] half_set_i,
  output logic              irq_o
);
  import irq_pkg::*;

  logic              wr_pend, wr_en;
  logic [SRC_W-1:0]  gen_pend, gen_clr;
  logic              loop_any;
  logic [CH_W-1:0]   loop_top;
  logic [DATA_W-1:0] en_q, pend_word;

  assign wr_pend = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_PEND);
  assign wr_en   = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_EN);
  assign gen_clr = wr_pend ? reg_wdata_i[DATA_W-1:SRC_LO] : '0;

  irq_gen_pending #(.SRC_W(SRC_W)) u_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (src_set_i),
    .clr_i  (gen_clr),
    .pend_o (gen_pend)
  );

  irq_loop_bank #(.NUM_CH(NUM_CH)) u_loop (
    .clk        (clk),
    .rst_n      (rst_n),
    .loop_set_i (loop_set_i),
    .half_set_i (half_set_i),
    .clr_en_i   (wr_pend && reg_wdata_i[SUM_BIT]),
    .clr_ch_i   (reg_wdata_i[CH_W-1:0]),
    .any_o      (loop_any),
    .top_ch_o   (loop_top)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= reg_wdata_i;
  end

  assign pend_word   = {gen_pend, loop_any, loop_top};
  assign reg_rdata_o = (reg_sel_e'(reg_sel_i) == SEL_EN) ? en_q : pend_word;

  irq_line #(.DATA_W(DATA_W), .LOW_W(SUM_BIT), .FORCE_BIT(FORCE_BIT)) u_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (pend_word),
    .en_i   (en_q),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/irq_loop_ctrl_chk.sv
module irq_loop_ctrl_chk #(
  parameter int DATA_W    = 32,
  parameter int NUM_CH    = 64,
  parameter int FORCE_BIT = 20,
  parameter int CH_W      = 6,
  parameter int SRC_W     = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_sel_i,
  input logic              reg_wr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [SRC_W-1:0]  src_set_i,
  input logic [NUM_CH-1:0] loop_set_i,
  input logic [NUM_CH-1:0] half_set_i,
  input logic [DATA_W-1:0] pend_word,
  input logic [DATA_W-1:0] en_q,
  input logic              irq_o
);
  logic [SRC_W-1:0] clr_eff;
  assign clr_eff = (reg_wr_i && !reg_sel_i) ? (reg_wdata_i[DATA_W-1:CH_W+1] & ~src_set_i) : '0;

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_eff) |=> ((pend_word[DATA_W-1:CH_W+1] & $past(clr_eff)) == '0)); // R2

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_set_i) |=> ((pend_word[DATA_W-1:CH_W+1] & $past(src_set_i)) == $past(src_set_i))); // R3

  AST_LOOP_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (|(loop_set_i | half_set_i)) |=> pend_word[CH_W]); // R4

  AST_IDLE_CH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_word[CH_W] |-> (pend_word[CH_W-1:0] == '0)); // R5

  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_sel_i) |=> (en_q == $past(reg_wdata_i))); // R8

  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[FORCE_BIT] |=> irq_o); // R10
endmodule

bind irq_loop_ctrl irq_loop_ctrl_chk #(
  .DATA_W(DATA_W), .NUM_CH(NUM_CH), .FORCE_BIT(FORCE_BIT), .CH_W(CH_W), .SRC_W(SRC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel_i(reg_sel_i), .reg_wr_i(reg_wr_i),
  .reg_wdata_i(reg_wdata_i), .src_set_i(src_set_i), .loop_set_i(loop_set_i),
  .half_set_i(half_set_i), .pend_word(pend_word), .en_q(en_q), .irq_o(irq_o)
);

// File: tb/irq_loop_ctrl_tb_top.sv
module irq_loop_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [24:0] src_set_i = '0;
  logic [63:0] loop_set_i = '0;
  logic [63:0] half_set_i = '0;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_loop_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel_i(reg_sel_i), .reg_wr_i(reg_wr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .src_set_i(src_set_i),
    .loop_set_i(loop_set_i), .half_set_i(half_set_i), .irq_o(irq_o)
  );

  typedef struct packed {
    logic        sel;
    logic        wr;
    logic [31:0] wdata;
    logic [24:0] src;
    logic [31:0] exp_pend;
    logic        exp_irq;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b1, 1'b1, 32'h0000_0080, 25'h0, 32'h0000_0000, 1'b0},  // R8 enable bit 7
    '{1'b0, 1'b0, 32'h0,         25'h1, 32'h0000_0080, 1'b1},  // R2 R9 source bit 7
    '{1'b0, 1'b0, 32'h0,         25'h4, 32'h0000_0280, 1'b1},  // R2 source bit 9
    '{1'b0, 1'b1, 32'h0000_0080, 25'h0, 32'h0000_0200, 1'b0},  // R2 R9 clear bit 7
    '{1'b0, 1'b1, 32'h0000_0200, 25'h4, 32'h0000_0200, 1'b0},  // R3 set beats clear
    '{1'b0, 1'b1, 32'h0000_0000, 25'h0, 32'h0000_0200, 1'b0},  // R2 zeros keep
    '{1'b1, 1'b1, 32'h0000_0200, 25'h0, 32'h0000_0200, 1'b1},  // R9 enable bit 9
    '{1'b1, 1'b1, 32'h0010_0000, 25'h0, 32'h0000_0200, 1'b1},  // R10 force only
    '{1'b1, 1'b1, 32'h0000_0000, 25'h0, 32'h0000_0200, 1'b0},  // R9 all disabled
    '{1'b0, 1'b1, 32'hFFFF_FF80, 25'h0, 32'h0000_0000, 1'b0}   // R2 clear all
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // drive one cycle, then idle one cycle so irq_o settles; sample on falling edge
  task automatic apply(input logic sel, input logic wr, input logic [31:0] wd,
                       input logic [24:0] src, input logic [63:0] lp, input logic [63:0] hp);
    reg_sel_i = sel; reg_wr_i = wr; reg_wdata_i = wd;
    src_set_i = src; loop_set_i = lp; half_set_i = hp;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_wdata_i = '0; src_set_i = '0;
    loop_set_i = '0; half_set_i = '0; reg_sel_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    reg_sel_i = 1'b0;
    check("R1 pend", reg_rdata_o, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    reg_sel_i = 1'b1; #1;
    check("R1 en", reg_rdata_o, 32'h0);
    reg_sel_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      apply(VECS[i].sel, VECS[i].wr, VECS[i].wdata, VECS[i].src, '0, '0);
      check($sformatf("R2/R3/R9 row %0d pend", i), reg_rdata_o, VECS[i].exp_pend);
      check($sformatf("R9/R10 row %0d irq", i), {31'b0, irq_o}, {31'b0, VECS[i].exp_irq});
    end

    // R8 enable readback of a wide pattern
    apply(1'b1, 1'b1, 32'hA5C3_0F40, '0, '0, '0);
    reg_sel_i = 1'b1; #1;
    check("R8 en readback", reg_rdata_o, 32'hA5C3_0F40);
    reg_sel_i = 1'b0;
    apply(1'b1, 1'b1, 32'h0000_0040, '0, '0, '0);  // enable only summary

    // R4 R5 loop ch5 and half ch40
    apply(1'b0, 1'b0, '0, '0, 64'h1 << 5, 64'h1 << 40);
    check("R4 R5 two channels", reg_rdata_o, 32'h40 | 32'd40);
    check("R9 summary irq", {31'b0, irq_o}, 32'h1);

    // R6 clear ch40
    apply(1'b0, 1'b1, 32'h40 | 32'd40, '0, '0, '0);
    check("R6 clear ch40", reg_rdata_o, 32'h40 | 32'd5);
    // R6 clear idle channel 63: no change
    apply(1'b0, 1'b1, 32'h40 | 32'd63, '0, '0, '0);
    check("R6 clear idle ch", reg_rdata_o, 32'h45);
    // R6 write without bit 6: no change
    apply(1'b0, 1'b1, 32'h0000_0005, '0, '0, '0);
    check("R6 no flag no clear", reg_rdata_o, 32'h45);
    // R7 set on ch5 in clearing cycle wins
    apply(1'b0, 1'b1, 32'h45, '0, 64'h1 << 5, '0);
    check("R7 set beats clear", reg_rdata_o, 32'h45);
    // R5 clear last, bits 5:0 back to zero
    apply(1'b0, 1'b1, 32'h45, '0, '0, '0);
    check("R5 idle reads zero", reg_rdata_o, 32'h0);
    check("R9 irq drops", {31'b0, irq_o}, 32'h0);

    // R5 boundary channel 63 via half flag
    apply(1'b0, 1'b0, '0, '0, '0, 64'h1 << 63);
    check("R5 ch63", reg_rdata_o, 32'h7F);
    apply(1'b0, 1'b1, 32'h7F, '0, '0, '0);
    check("R6 clear ch63", reg_rdata_o, 32'h0);
    // R4 boundary channel 0: summary set, number zero
    apply(1'b0, 1'b0, '0, '0, 64'h1, '0);
    check("R4 ch0", reg_rdata_o, 32'h40);
    // R6 both flags of one channel cleared together
    apply(1'b0, 1'b0, '0, '0, '0, 64'h1);
    apply(1'b0, 1'b1, 32'h40, '0, '0, '0);
    check("R6 both flags ch0", reg_rdata_o, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule